// File: doc/BRIEF.md
# Output Clock Gating and Power-Down Sequencer

This block sits between a clock synthesizer's internal dividers and its output pads. It receives free-running phases for six clock groups: host, interrupt-controller, 66 MHz, bus, reference and 48 MHz. It produces the gated versions that leave the chip. Each output has its own enable bit. An enable bit changes the gate only while that output's phase is low, so a gated clock never shows a shortened pulse. A single control bit floats every pad through one shared output-enable.

An asynchronous active-low power-down pin is first passed through a two-stage synchronizer. Once the request is seen, the gates stop opening and each output freezes low at its own next low phase. The oscillator and VCO enables fall only after every gate has closed. When the pin is released, the oscillator is enabled again, the VCO one cycle later, and all outputs stay low for a programmable settling count before they run. The same settling count applies after reset.

The block also picks the 5-bit frequency code, either from pins captured once after reset or from bits of the control byte. It also builds the selectable output, which carries either the 48 MHz phase or that phase divided by two.

Top module: `clkout_gate_seq`

## Requirements
- R1: `pd_ni` is synchronized by two flops, so outputs keep running for at least the two sampling edges after it falls. The oscillator enable only falls while the synchronized request is active.
- R2: During power-down every output is held low, including the reference, 48 MHz, selectable and free-running bus clocks.
- R3: `osc_en_o` and `vco_en_o` fall only after every output is low. They are low while the block is powered down. `vco_en_o` is never high while `osc_en_o` is low. Both return within a few cycles of `pd_ni` rising.
- R4: After reset, and after every power-down exit, all outputs stay low for `WAKE_CYC` clock cycles. After that they run.
- R5: An output whose enable bit is 1 follows its phase. An output whose enable bit is 0 stays low and does not switch.
- R6: An enable change takes effect only while that output's phase is low. A gated output rises only together with its phase and falls only together with it.
- R7: `ctrl_i[0]` = 1 drives `out_oe_o` low (all pads floating). `ctrl_i[0]` = 0 drives it high.
- R8: With `ctrl_i[3]` = 0, `fs_o` is the value of `fs_pin_i` captured at the first rising clock edge after reset. Later changes on `fs_pin_i` are ignored.
- R9: With `ctrl_i[3]` = 1, `fs_o` = {`ctrl_i[2]`, `ctrl_i[7:4]`}, with `ctrl_i[2]` as the most significant bit.
- R10: With `sel24_i` = 0, `sel_clk_o` carries the 48 MHz phase. With `sel24_i` = 1 it carries that phase divided by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer and sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_ni | input | 1 | Asynchronous active-low power-down request |
| cpu_ph_i | input | 1 | Free-running host clock phase |
| apic_ph_i | input | 1 | Free-running interrupt-controller clock phase |
| v66_ph_i | input | 1 | Free-running 66 MHz phase |
| pci_ph_i | input | 1 | Free-running bus clock phase |
| ref_ph_i | input | 1 | Free-running reference phase |
| f48_ph_i | input | 1 | Free-running 48 MHz phase |
| ctrl_i | input | 8 | Control byte: bit 0 float, bit 3 code source, bits 2 and 7:4 code |
| fs_pin_i | input | 5 | Frequency-select pins |
| sel24_i | input | 1 | 1 selects the divided output, 0 the 48 MHz output |
| cpu_en_i | input | N_CPU | Host clock enables |
| apic_en_i | input | N_APIC | Interrupt-controller clock enables |
| v66_en_i | input | N_V66 | 66 MHz clock enables |
| pci_en_i | input | N_PCI | Bus clock enables, bit 0 is the free-running one |
| ref_en_i | input | N_REF | Reference clock enables |
| f48_en_i | input | 1 | 48 MHz output enable |
| sel_en_i | input | 1 | Selectable output enable |
| cpu_clk_o | output | N_CPU | Gated host clocks |
| apic_clk_o | output | N_APIC | Gated interrupt-controller clocks |
| v66_clk_o | output | N_V66 | Gated 66 MHz clocks |
| pci_clk_o | output | N_PCI | Gated bus clocks |
| ref_clk_o | output | N_REF | Gated reference clocks |
| f48_clk_o | output | 1 | Gated 48 MHz clock |
| sel_clk_o | output | 1 | Gated 24/48 MHz clock |
| out_oe_o | output | 1 | Shared pad output enable |
| osc_en_o | output | 1 | Crystal oscillator enable |
| vco_en_o | output | 1 | VCO enable |
| fs_o | output | 5 | Selected frequency code |

## Verification
The hardest case to reach is the ordering at power-down entry. Outputs with unrelated phase periods close their gates on different cycles, and the oscillator must not fall while even one of them is still high. The bench runs six phases with coprime-ish periods, so at the moment the request lands some phases are high and others are low. It drops `pd_ni` at an arbitrary point in that pattern. A per-cycle monitor flags any cycle where the oscillator is off while an output is high. The same monitor flags any output edge that does not coincide with its phase edge, while enables are flipped in the middle of high phases.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int unsigned FS_W = 5;
  typedef enum logic [1:0] {PD_WAKE, PD_RUN, PD_STOP, PD_OFF} pd_state_e;
endpackage

// File: rtl/clkout_pd_seq.sv
module clkout_pd_seq
  import clkout_pkg::*;
#(
  parameter int unsigned WAKE_CYC = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  input  logic all_off_i,
  output logic pd_req_o,
  output logic run_o,
  output logic osc_en_o,
  output logic vco_en_o
);
  localparam int unsigned CW = $clog2(WAKE_CYC + 1);

  logic [1:0]    sync_q;
  pd_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], ~pd_ni};
  end
  assign pd_req_o = sync_q[1];

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PD_WAKE: begin
        if (pd_req_o) begin
          st_d  = PD_STOP;
          cnt_d = '0;
        end else if (cnt_q == CW'(WAKE_CYC - 1)) begin
          st_d  = PD_RUN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PD_RUN:  if (pd_req_o) st_d = PD_STOP;
      PD_STOP: if (all_off_i) st_d = PD_OFF;
      PD_OFF:  if (!pd_req_o) begin
        st_d  = PD_WAKE;
        cnt_d = '0;
      end
      default: st_d = PD_WAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PD_WAKE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign run_o    = (st_q == PD_RUN);
  assign osc_en_o = (st_q != PD_OFF);
  // VCO follows the oscillator by one cycle on wake
  assign vco_en_o = osc_en_o && !((st_q == PD_WAKE) && (cnt_q == '0));
endmodule

// File: rtl/clkout_gate_cell.sv
module clkout_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph_i,
  input  logic en_i,
  output logic en_q_o,
  output logic gclk_o
);
  logic en_q;

  // enable only moves while the phase is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= 1'b0;
    else if (!ph_i) en_q <= en_i;
  end

  assign en_q_o = en_q;
  assign gclk_o = ph_i & en_q;
endmodule

// File: rtl/clkout_fs_pick.sv
module clkout_fs_pick
  import clkout_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FS_W-1:0] fs_pin_i,
  input  logic            reg_sel_i,
  input  logic [FS_W-1:0] reg_code_i,
  output logic            taken_o,
  output logic [FS_W-1:0] fs_o
);
  logic            taken_q;
  logic [FS_W-1:0] pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q <= 1'b0;
      pin_q   <= '0;
    end else if (!taken_q) begin
      taken_q <= 1'b1;
      pin_q   <= fs_pin_i;
    end
  end

  assign taken_o = taken_q;
  assign fs_o    = reg_sel_i ? reg_code_i : pin_q;
endmodule

// File: rtl/clkout_div_sel.sv
module clkout_div_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic f48_ph_i,
  input  logic sel24_i,
  output logic ph_o
);
  logic f48_q, div_q, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f48_q <= 1'b0;
      div_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      f48_q <= f48_ph_i;
      if (f48_ph_i && !f48_q) div_q <= ~div_q;
      // swap source only while both candidates are low
      if (!f48_ph_i && !div_q) sel_q <= sel24_i;
    end
  end

  assign ph_o = sel_q ? div_q : f48_ph_i;
endmodule

// File: rtl/clkout_gate_seq.sv
module clkout_gate_seq
  import clkout_pkg::*;
#(
  parameter int unsigned N_CPU    = 4,
  parameter int unsigned N_APIC   = 3,
  parameter int unsigned N_V66    = 3,
  parameter int unsigned N_PCI    = 11,
  parameter int unsigned N_REF    = 2,
  parameter int unsigned WAKE_CYC = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_ni,
  input  logic              cpu_ph_i,
  input  logic              apic_ph_i,
  input  logic              v66_ph_i,
  input  logic              pci_ph_i,
  input  logic              ref_ph_i,
  input  logic              f48_ph_i,
  input  logic [7:0]        ctrl_i,
  input  logic [FS_W-1:0]   fs_pin_i,
  input  logic              sel24_i,
  input  logic [N_CPU-1:0]  cpu_en_i,
  input  logic [N_APIC-1:0] apic_en_i,
  input  logic [N_V66-1:0]  v66_en_i,
  input  logic [N_PCI-1:0]  pci_en_i,
  input  logic [N_REF-1:0]  ref_en_i,
  input  logic              f48_en_i,
  input  logic              sel_en_i,
  output logic [N_CPU-1:0]  cpu_clk_o,
  output logic [N_APIC-1:0] apic_clk_o,
  output logic [N_V66-1:0]  v66_clk_o,
  output logic [N_PCI-1:0]  pci_clk_o,
  output logic [N_REF-1:0]  ref_clk_o,
  output logic              f48_clk_o,
  output logic              sel_clk_o,
  output logic              out_oe_o,
  output logic              osc_en_o,
  output logic              vco_en_o,
  output logic [FS_W-1:0]   fs_o
);
  localparam int unsigned O_CPU  = 0;
  localparam int unsigned O_APIC = O_CPU + N_CPU;
  localparam int unsigned O_V66  = O_APIC + N_APIC;
  localparam int unsigned O_PCI  = O_V66 + N_V66;
  localparam int unsigned O_REF  = O_PCI + N_PCI;
  localparam int unsigned O_F48  = O_REF + N_REF;
  localparam int unsigned O_SEL  = O_F48 + 1;
  localparam int unsigned N_OUT  = O_SEL + 1;

  logic             run, pd_req, fs_taken, sel_ph, all_off;
  logic [N_OUT-1:0] ph_vec, en_vec, en_q_vec, out_vec;
  logic             unused_spread;

  assign unused_spread = ctrl_i[1];

  clkout_pd_seq #(.WAKE_CYC(WAKE_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pd_ni     (pd_ni),
    .all_off_i (all_off),
    .pd_req_o  (pd_req),
    .run_o     (run),
    .osc_en_o  (osc_en_o),
    .vco_en_o  (vco_en_o)
  );

  clkout_div_sel u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .f48_ph_i (f48_ph_i),
    .sel24_i  (sel24_i),
    .ph_o     (sel_ph)
  );

  clkout_fs_pick u_fs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fs_pin_i   (fs_pin_i),
    .reg_sel_i  (ctrl_i[3]),
    .reg_code_i ({ctrl_i[2], ctrl_i[7:4]}),
    .taken_o    (fs_taken),
    .fs_o       (fs_o)
  );

  assign ph_vec = {sel_ph, f48_ph_i, {N_REF{ref_ph_i}}, {N_PCI{pci_ph_i}},
                   {N_V66{v66_ph_i}}, {N_APIC{apic_ph_i}}, {N_CPU{cpu_ph_i}}};
  assign en_vec = {sel_en_i, f48_en_i, ref_en_i, pci_en_i, v66_en_i, apic_en_i, cpu_en_i}
                  & {N_OUT{run}};

  for (genvar g = 0; g < N_OUT; g++) begin : g_gate
    clkout_gate_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ph_i   (ph_vec[g]),
      .en_i   (en_vec[g]),
      .en_q_o (en_q_vec[g]),
      .gclk_o (out_vec[g])
    );
  end

  assign all_off = ~|en_q_vec;

  assign cpu_clk_o  = out_vec[O_CPU  +: N_CPU];
  assign apic_clk_o = out_vec[O_APIC +: N_APIC];
  assign v66_clk_o  = out_vec[O_V66  +: N_V66];
  assign pci_clk_o  = out_vec[O_PCI  +: N_PCI];
  assign ref_clk_o  = out_vec[O_REF  +: N_REF];
  assign f48_clk_o  = out_vec[O_F48];
  assign sel_clk_o  = out_vec[O_SEL];
  assign out_oe_o   = ~ctrl_i[0];
endmodule

// File: rtl/clkout_gate_seq_chk.sv
module clkout_gate_seq_chk
  import clkout_pkg::*;
#(
  parameter int unsigned N_OUT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pd_req,
  input logic             fs_taken,
  input logic [7:0]       ctrl_i,
  input logic [FS_W-1:0]  fs_o,
  input logic             osc_en_o,
  input logic             vco_en_o,
  input logic [N_OUT-1:0] ph_vec,
  input logic [N_OUT-1:0] out_vec
);
  AST_OSC_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (out_vec == '0)); // R3

  AST_VCO_UNDER_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vco_en_o |-> osc_en_o); // R3

  AST_OFF_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> $past(pd_req)); // R1

  AST_WAKE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> (out_vec == '0)); // R4

  AST_FS_PIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_taken && $past(fs_taken) && !ctrl_i[3] && !$past(ctrl_i[3])) |-> $stable(fs_o)); // R8

  for (genvar g = 0; g < N_OUT; g++) begin : g_edge
    AST_RISE_WITH_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(out_vec[g]) |-> $rose(ph_vec[g])); // R6
    AST_FALL_WITH_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(out_vec[g]) |-> $fell(ph_vec[g])); // R6
  end
endmodule

bind clkout_gate_seq clkout_gate_seq_chk #(.N_OUT(N_OUT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pd_req   (pd_req),
  .fs_taken (fs_taken),
  .ctrl_i   (ctrl_i),
  .fs_o     (fs_o),
  .osc_en_o (osc_en_o),
  .vco_en_o (vco_en_o),
  .ph_vec   (ph_vec),
  .out_vec  (out_vec)
);

// File: tb/clkout_gate_seq_tb.sv
`timescale 1ns/1ps
module clkout_gate_seq_tb;
  localparam int unsigned WAKE = 20;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pd_ni = 1'b1;
  logic [7:0]  ctrl = 8'h00;
  logic [4:0]  fs_pin = 5'b10110;
  logic        sel24 = 1'b0;
  logic [3:0]  cpu_en = '1;
  logic [2:0]  apic_en = '1;
  logic [2:0]  v66_en = '1;
  logic [10:0] pci_en = '1;
  logic [1:0]  ref_en = '1;
  logic        f48_en = 1'b1;
  logic        sel_en = 1'b1;
  int unsigned ph_cnt = 0;
  logic cpu_ph, apic_ph, v66_ph, pci_ph, ref_ph, f48_ph;

  logic [3:0]  cpu_clk;
  logic [2:0]  apic_clk;
  logic [2:0]  v66_clk;
  logic [10:0] pci_clk;
  logic [1:0]  ref_clk;
  logic        f48_clk, sel_clk, out_oe, osc_en, vco_en;
  logic [4:0]  fs;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int runt_viol = 0;
  int osc_viol = 0;

  always #5 clk = ~clk;
  always @(negedge clk) ph_cnt <= ph_cnt + 1;
  assign cpu_ph  = ph_cnt[0];
  assign v66_ph  = ph_cnt[1];
  assign pci_ph  = ph_cnt[2];
  assign apic_ph = ph_cnt[3];
  assign f48_ph  = (ph_cnt % 6) < 3;
  assign ref_ph  = (ph_cnt % 10) < 5;

  clkout_gate_seq #(.WAKE_CYC(WAKE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pd_ni(pd_ni),
    .cpu_ph_i(cpu_ph), .apic_ph_i(apic_ph), .v66_ph_i(v66_ph),
    .pci_ph_i(pci_ph), .ref_ph_i(ref_ph), .f48_ph_i(f48_ph),
    .ctrl_i(ctrl), .fs_pin_i(fs_pin), .sel24_i(sel24),
    .cpu_en_i(cpu_en), .apic_en_i(apic_en), .v66_en_i(v66_en),
    .pci_en_i(pci_en), .ref_en_i(ref_en), .f48_en_i(f48_en), .sel_en_i(sel_en),
    .cpu_clk_o(cpu_clk), .apic_clk_o(apic_clk), .v66_clk_o(v66_clk),
    .pci_clk_o(pci_clk), .ref_clk_o(ref_clk), .f48_clk_o(f48_clk),
    .sel_clk_o(sel_clk), .out_oe_o(out_oe), .osc_en_o(osc_en),
    .vco_en_o(vco_en), .fs_o(fs)
  );

  function automatic logic any_out();
    return |{cpu_clk, apic_clk, v66_clk, pci_clk, ref_clk, f48_clk, sel_clk};
  endfunction

  // per-cycle monitor: output edges must match phase edges; osc off means all low
  logic [3:0] m_out_q, m_ph_q;
  always @(posedge clk) begin
    logic [3:0] mo, mp;
    #2;
    mo = {ref_clk[0], pci_clk[0], cpu_clk[1], cpu_clk[0]};
    mp = {ref_ph, pci_ph, cpu_ph, cpu_ph};
    if (rst_ni) begin
      for (int i = 0; i < 4; i++) begin
        if (mo[i] && !m_out_q[i] && !(mp[i] && !m_ph_q[i])) runt_viol++;
        if (!mo[i] && m_out_q[i] && !(!mp[i] && m_ph_q[i])) runt_viol++;
      end
      if (!osc_en && any_out()) osc_viol++;
    end
    m_out_q = mo;
    m_ph_q  = mp;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic t_reset_wake();
    step(3);
    rst_ni = 1'b1;
    step(2);
    fs_pin = 5'b01001;
    step(8);
    chk(!any_out(), "R4 outputs low during settle after reset", any_out(), 0);
    chk(osc_en && vco_en, "R3 oscillator and VCO on during settle", {osc_en, vco_en}, 3);
    chk(fs == 5'b10110, "R8 code from pins captured after reset", fs, 5'b10110);
    step(WAKE + 5);
  endtask

  task automatic t_run();
    int mism = 0;
    for (int i = 0; i < 16; i++) begin
      if (cpu_clk[0] != cpu_ph || pci_clk[0] != pci_ph || ref_clk[1] != ref_ph) mism++;
      step(1);
    end
    chk(mism == 0, "R5 enabled outputs follow phases", mism, 0);
  endtask

  task automatic t_enable();
    int highs = 0;
    int mism = 0;
    wait (cpu_ph == 1'b1);
    #1;
    cpu_en[1] = 1'b0;
    ref_en[0] = 1'b0;
    step(12);
    for (int i = 0; i < 12; i++) begin
      if (cpu_clk[1] || ref_clk[0]) highs++;
      step(1);
    end
    chk(highs == 0, "R5 disabled outputs held low", highs, 0);
    wait (cpu_ph == 1'b1);
    #1;
    cpu_en[1] = 1'b1;
    ref_en[0] = 1'b1;
    step(12);
    for (int i = 0; i < 12; i++) begin
      if (cpu_clk[1] != cpu_ph || ref_clk[0] != ref_ph) mism++;
      step(1);
    end
    chk(mism == 0, "R5 re-enabled outputs follow phases", mism, 0);
    chk(runt_viol == 0, "R6 no shortened pulse on enable change", runt_viol, 0);
  endtask

  task automatic t_tristate();
    ctrl = 8'h01;
    #1;
    chk(out_oe == 1'b0, "R7 float bit set", out_oe, 0);
    ctrl = 8'h00;
    #1;
    chk(out_oe == 1'b1, "R7 float bit clear", out_oe, 1);
  endtask

  task automatic t_fs();
    ctrl = 8'b1010_1100;
    step(1);
    chk(fs == 5'b11010, "R9 code from control bits", fs, 5'b11010);
    ctrl = 8'b0101_0000;
    fs_pin = 5'b00111;
    step(2);
    chk(fs == 5'b10110, "R8 pin change after capture ignored", fs, 5'b10110);
    ctrl = 8'h00;
  endtask

  task automatic t_sel();
    int sr = 0;
    int fr = 0;
    logic sp, fp;
    sel24 = 1'b0;
    step(20);
    sp = sel_clk; fp = f48_ph;
    for (int i = 0; i < 120; i++) begin
      step(1);
      if (sel_clk && !sp) sr++;
      if (f48_ph && !fp) fr++;
      sp = sel_clk; fp = f48_ph;
    end
    chk(sr == fr, "R10 48 MHz selection", sr, fr);
    sel24 = 1'b1;
    step(30);
    sr = 0; fr = 0;
    sp = sel_clk; fp = f48_ph;
    for (int i = 0; i < 120; i++) begin
      step(1);
      if (sel_clk && !sp) sr++;
      if (f48_ph && !fp) fr++;
      sp = sel_clk; fp = f48_ph;
    end
    chk(sr >= fr / 2 - 1 && sr <= fr / 2 + 1, "R10 divided selection", sr, fr / 2);
    sel24 = 1'b0;
    step(20);
  endtask

  task automatic t_pd();
    int highs = 0;
    int runs = 0;
    pd_ni = 1'b0;
    for (int i = 0; i < 2; i++) begin
      step(1);
      if (cpu_clk[0]) highs++;
    end
    chk(highs >= 1, "R1 outputs run through synchronizer", highs, 1);
    chk(osc_en == 1'b1, "R1 oscillator still on right after request", osc_en, 1);
    step(40);
    chk(!any_out(), "R2 all outputs low in power-down", any_out(), 0);
    chk(!osc_en && !vco_en, "R3 oscillator and VCO off", {osc_en, vco_en}, 0);
    chk(osc_viol == 0, "R3 enables fell only after outputs low", osc_viol, 0);
    pd_ni = 1'b1;
    step(5);
    chk(osc_en && vco_en, "R3 enables back after release", {osc_en, vco_en}, 3);
    step(8);
    chk(!any_out(), "R4 outputs low during settle after release", any_out(), 0);
    step(WAKE + 5);
    for (int i = 0; i < 4; i++) begin
      step(1);
      if (cpu_clk[0]) runs++;
    end
    chk(runs > 0, "R4 outputs run after settle", runs, 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_wake();
    t_run();
    t_enable();
    t_tristate();
    t_fs();
    t_sel();
    t_pd();
    chk(runt_viol == 0, "R6 edge monitor over whole run", runt_viol, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule